// File: doc/BRIEF.md
# Converter Result Refinement Pipeline

This block sits behind an analog-to-digital converter and turns each raw sample into a final result. Each raw sample arrives with a valid strobe and the number of the channel that produced it. The block first corrects the sample against an offset slot that names its channel. It then optionally scales the sample by a fixed-point gain. Next it accumulates a programmable number of samples and shifts the sum right. Finally it shifts the result left and emits it with its own valid strobe.

Four offset slots each hold a channel number, an offset magnitude, a direction bit that selects add or subtract, and two saturation enables. The gain coefficient is a 14-bit unsigned value with twelve fractional bits, so a coefficient of 4096 means unity. The oversampling fields set the number of samples per result and the right shift applied to their sum. A separate left shift scales every result. All configuration inputs are expected to be held steady while samples are flowing.

Top module: `sample_refine`

## Requirements
- R1: While reset is high, and on the clock edge that samples it, `out_valid` is driven low.
- R2: Slots are numbered 0 to 3. A slot applies to a sample when its `slot_chan` field equals `in_chan`. When several slots name the same channel, the lowest-numbered one is used. With `slot_add` low, its `slot_ofs` value is subtracted from the raw sample.
- R3: If no slot names the channel, or if the selected slot has an offset of zero, the raw sample passes through unchanged and is not saturated.
- R4: With `slot_add` high on the selected slot, the offset is added to the raw sample instead of subtracted.
- R5: With `slot_usat` high and `slot_ssat` low on the selected slot, a negative corrected value becomes zero and a non-negative one is kept.
- R6: With `slot_ssat` high on the selected slot, the corrected value is clamped to the range -2^(RAW_W-1) to 2^(RAW_W-1)-1. This takes precedence over `slot_usat`.
- R7: With `gain_en` high, the corrected value v becomes floor((v*`gain_coef` + 2048) / 4096). With `gain_en` low, v passes through unchanged.
- R8: With `ovs_en` high, an `ovs_ratio` of N sums N+1 consecutive samples (N from 0 to 1023) and gives one `out_valid` pulse per N+1 samples. The sum is shifted right arithmetically by `ovs_rshift`.
- R9: The result is shifted left by `res_lshift`, whether or not oversampling is on. With `ovs_en` low, `ovs_rshift` has no effect and every sample produces a result.
- R10: `out_valid` rises three clock edges after the edge that accepts the last sample of a result. It never rises without such a sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Raw sample strobe |
| in_chan | input | CH_W | Channel number of the sample |
| in_data | input | RAW_W | Raw unsigned sample |
| slot_chan | input | NSLOT x CH_W | Channel named by each offset slot |
| slot_ofs | input | NSLOT x OFS_W | Offset magnitude of each slot |
| slot_add | input | NSLOT | Per-slot add instead of subtract |
| slot_usat | input | NSLOT | Per-slot clamp of negatives to zero |
| slot_ssat | input | NSLOT | Per-slot signed-range clamp |
| gain_en | input | 1 | Enables gain compensation |
| gain_coef | input | 14 | Gain coefficient, unity at 4096 |
| ovs_en | input | 1 | Enables oversampling accumulation |
| ovs_ratio | input | 10 | Samples per result minus one |
| ovs_rshift | input | 4 | Right shift of the accumulated sum |
| res_lshift | input | 4 | Left shift of the final result |
| out_valid | output | 1 | Result strobe |
| out_data | output | OUT_W | Signed processed result |

## Verification
The hardest case to reach from the ports is the full 1024-sample accumulation. The stimulus drives it with 1024 back-to-back full-scale samples while the bench counts result pulses. This shows that a single result appears and that the wide sum survives the shift exactly. Slot shadowing is also hard to see from outside, because a correct block and a block that picks the wrong slot can give the same result. The bench therefore loads two slots with the same channel but different offsets and directions, so each choice of slot gives a distinct value. The saturation and gain tests reprogram slots between samples, and they include inputs that round a negative value and drive both clamp limits.

// File: rtl/sr_pkg.sv
package sr_pkg;

    localparam int SR_GAIN_W = 14;
    localparam int SR_FRAC_W = 12;
    localparam int SR_OVS_W  = 10;
    localparam int SR_SH_W   = 4;

    typedef enum logic [1:0] {
        SAT_NONE     = 2'd0,
        SAT_UNSIGNED = 2'd1,
        SAT_SIGNED   = 2'd2
    } sat_mode_e;

    typedef struct packed {
        logic                en;
        logic [SR_OVS_W-1:0] ratio;
        logic [SR_SH_W-1:0]  rshift;
        logic [SR_SH_W-1:0]  lshift;
    } ovs_cfg_t;

    function automatic sat_mode_e sat_pick(input logic usat, input logic ssat);
        if (ssat)      return SAT_SIGNED;
        else if (usat) return SAT_UNSIGNED;
        else           return SAT_NONE;
    endfunction

endpackage

// File: rtl/sr_offset.sv
module sr_offset
    import sr_pkg::*;
#(
    parameter int NSLOT = 4,
    parameter int CH_W  = 5,
    parameter int RAW_W = 12,
    parameter int OFS_W = 12,
    parameter int VW    = 14
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         in_valid,
    input  logic [CH_W-1:0]              in_chan,
    input  logic [RAW_W-1:0]             in_data,
    input  logic [NSLOT-1:0][CH_W-1:0]   slot_chan,
    input  logic [NSLOT-1:0][OFS_W-1:0]  slot_ofs,
    input  logic [NSLOT-1:0]             slot_add,
    input  logic [NSLOT-1:0]             slot_usat,
    input  logic [NSLOT-1:0]             slot_ssat,
    output logic                         o_valid,
    output logic signed [VW-1:0]         o_val
);
    localparam int SW = (NSLOT > 1) ? $clog2(NSLOT) : 1;
    localparam logic signed [VW-1:0] SMAX = VW'((1 << (RAW_W-1)) - 1);
    localparam logic signed [VW-1:0] SMIN = -SMAX - VW'(1);

    logic [NSLOT-1:0]       hit;
    logic [SW-1:0]          sel;
    logic                   found;
    logic signed [VW-1:0]   raw_s, ofs_s, sum, corr;
    sat_mode_e              mode;

    for (genvar g = 0; g < NSLOT; g++) begin : g_match
        assign hit[g] = (slot_chan[g] == in_chan);
    end

    // Scan downward so the lowest matching slot wins.
    always_comb begin
        sel   = '0;
        found = 1'b0;
        for (int i = NSLOT-1; i >= 0; i--) begin
            if (hit[i]) begin
                sel   = SW'(i);
                found = 1'b1;
            end
        end
    end

    assign raw_s = $signed({{(VW-RAW_W){1'b0}}, in_data});
    assign ofs_s = $signed({{(VW-OFS_W){1'b0}}, slot_ofs[sel]});
    assign mode  = sat_pick(slot_usat[sel], slot_ssat[sel]);
    assign sum   = slot_add[sel] ? (raw_s + ofs_s) : (raw_s - ofs_s);

    always_comb begin
        if (!found || slot_ofs[sel] == '0) begin
            corr = raw_s;
        end else begin
            unique case (mode)
                SAT_SIGNED:   corr = (sum > SMAX) ? SMAX : ((sum < SMIN) ? SMIN : sum);
                SAT_UNSIGNED: corr = (sum < 0) ? '0 : sum;
                default:      corr = sum;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) o_valid <= 1'b0;
        else     o_valid <= in_valid;
        if (in_valid) o_val <= corr;
    end
endmodule

// File: rtl/sr_gain.sv
module sr_gain
    import sr_pkg::*;
#(
    parameter int VW = 14,
    parameter int GW = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    i_valid,
    input  logic signed [VW-1:0]    i_val,
    input  logic                    gain_en,
    input  logic [SR_GAIN_W-1:0]    gain_coef,
    output logic                    o_valid,
    output logic signed [GW-1:0]    o_val
);
    localparam int PW = VW + SR_GAIN_W + 2;
    localparam logic signed [PW-1:0] HALF = PW'(1 << (SR_FRAC_W-1));

    logic signed [PW-1:0] prod, rnd, scaled;
    logic signed [GW-1:0] nxt;

    assign prod   = PW'(i_val) * $signed({2'b00, gain_coef});
    assign rnd    = prod + HALF;
    assign scaled = rnd >>> SR_FRAC_W;
    assign nxt    = gain_en ? scaled[GW-1:0] : GW'(i_val);

    always_ff @(posedge clk) begin
        if (rst) o_valid <= 1'b0;
        else     o_valid <= i_valid;
        if (i_valid) o_val <= nxt;
    end
endmodule

// File: rtl/sr_accum.sv
module sr_accum
    import sr_pkg::*;
#(
    parameter int GW    = 16,
    parameter int ACC_W = 26,
    parameter int OUT_W = 41
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    i_valid,
    input  logic signed [GW-1:0]    i_val,
    input  ovs_cfg_t                cfg,
    output logic                    o_valid,
    output logic signed [OUT_W-1:0] o_data
);
    logic signed [ACC_W-1:0] acc, total, shr;
    logic [SR_OVS_W-1:0]     cnt, lim;
    logic signed [OUT_W-1:0] wide, fin;

    assign lim   = cfg.en ? cfg.ratio : '0;
    assign total = acc + {{(ACC_W-GW){i_val[GW-1]}}, i_val};
    assign shr   = cfg.en ? (total >>> cfg.rshift) : total;
    assign wide  = {{(OUT_W-ACC_W){shr[ACC_W-1]}}, shr};
    assign fin   = wide <<< cfg.lshift;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc     <= '0;
            cnt     <= '0;
            o_valid <= 1'b0;
            o_data  <= '0;
        end else begin
            o_valid <= 1'b0;
            if (i_valid) begin
                if (cnt >= lim) begin
                    acc     <= '0;
                    cnt     <= '0;
                    o_valid <= 1'b1;
                    o_data  <= fin;
                end else begin
                    acc <= total;
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sample_refine.sv
module sample_refine
    import sr_pkg::*;
#(
    parameter int NSLOT = 4,
    parameter int CH_W  = 5,
    parameter int RAW_W = 12,
    parameter int OFS_W = 12,
    localparam int VW    = ((RAW_W > OFS_W) ? RAW_W : OFS_W) + 2,
    localparam int GW    = VW + 2,
    localparam int ACC_W = GW + SR_OVS_W,
    localparam int OUT_W = ACC_W + (1 << SR_SH_W) - 1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         in_valid,
    input  logic [CH_W-1:0]              in_chan,
    input  logic [RAW_W-1:0]             in_data,
    input  logic [NSLOT-1:0][CH_W-1:0]   slot_chan,
    input  logic [NSLOT-1:0][OFS_W-1:0]  slot_ofs,
    input  logic [NSLOT-1:0]             slot_add,
    input  logic [NSLOT-1:0]             slot_usat,
    input  logic [NSLOT-1:0]             slot_ssat,
    input  logic                         gain_en,
    input  logic [SR_GAIN_W-1:0]         gain_coef,
    input  logic                         ovs_en,
    input  logic [SR_OVS_W-1:0]          ovs_ratio,
    input  logic [SR_SH_W-1:0]           ovs_rshift,
    input  logic [SR_SH_W-1:0]           res_lshift,
    output logic                         out_valid,
    output logic [OUT_W-1:0]             out_data
);
    logic                  v1, v2;
    logic signed [VW-1:0]  d1;
    logic signed [GW-1:0]  d2;
    logic signed [OUT_W-1:0] res;
    ovs_cfg_t              cfg;

    assign cfg = '{en: ovs_en, ratio: ovs_ratio, rshift: ovs_rshift, lshift: res_lshift};

    sr_offset #(.NSLOT(NSLOT), .CH_W(CH_W), .RAW_W(RAW_W), .OFS_W(OFS_W), .VW(VW)) ofs_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_chan(in_chan), .in_data(in_data),
        .slot_chan(slot_chan), .slot_ofs(slot_ofs), .slot_add(slot_add),
        .slot_usat(slot_usat), .slot_ssat(slot_ssat), .o_valid(v1), .o_val(d1)
    );

    sr_gain #(.VW(VW), .GW(GW)) gain_i (
        .clk(clk), .rst(rst), .i_valid(v1), .i_val(d1),
        .gain_en(gain_en), .gain_coef(gain_coef), .o_valid(v2), .o_val(d2)
    );

    sr_accum #(.GW(GW), .ACC_W(ACC_W), .OUT_W(OUT_W)) acc_i (
        .clk(clk), .rst(rst), .i_valid(v2), .i_val(d2), .cfg(cfg),
        .o_valid(out_valid), .o_data(res)
    );

    assign out_data = res;
endmodule

// File: rtl/sr_checker.sv
module sr_checker #(
    parameter int OVS_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             ovs_en,
    input logic [OVS_W-1:0] ovs_ratio,
    input logic             out_valid
);
    logic       rst_q = 1'b0;
    logic [1:0] warm  = 2'd0;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst)              warm <= 2'd0;
        else if (warm != 2'd3) warm <= warm + 2'd1;
    end

    // R1: an edge that sampled reset leaves the strobe low
    always @(posedge clk) begin
        if (rst_q) begin
            p_reset_quiet_r1: assert (!out_valid)
                else $error("out_valid high after reset edge");
        end
    end

    p_latency_r10: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd3 && $past(in_valid, 3) && !$past(ovs_en)) |-> out_valid);

    p_no_spurious_r10: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd3 && out_valid) |-> $past(in_valid, 3));

    p_pulse_gap_r8: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> (!out_valid || !$past(ovs_en) || $past(ovs_ratio) == '0));
endmodule

bind sample_refine sr_checker #(.OVS_W(sr_pkg::SR_OVS_W)) chk_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .ovs_en(ovs_en),
    .ovs_ratio(ovs_ratio), .out_valid(out_valid)
);

// File: tb/sample_refine_tb_top.sv
module sample_refine_tb_top;
    localparam int NSLOT = 4, CH_W = 5, RAW_W = 12, OFS_W = 12;
    localparam int OUT_W = 41;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [CH_W-1:0] in_chan = '0;
    logic [RAW_W-1:0] in_data = '0;
    logic [NSLOT-1:0][CH_W-1:0]  slot_chan = '0;
    logic [NSLOT-1:0][OFS_W-1:0] slot_ofs = '0;
    logic [NSLOT-1:0] slot_add = '0, slot_usat = '0, slot_ssat = '0;
    logic gain_en = 1'b0;
    logic [13:0] gain_coef = 14'd4096;
    logic ovs_en = 1'b0;
    logic [9:0] ovs_ratio = '0;
    logic [3:0] ovs_rshift = '0, res_lshift = '0;
    logic out_valid;
    logic [OUT_W-1:0] out_data;

    int errors = 0, checks = 0, n_out = 0;
    longint got = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sample_refine #(.NSLOT(NSLOT), .CH_W(CH_W), .RAW_W(RAW_W), .OFS_W(OFS_W)) dut_i (.*);

    always @(negedge clk) begin
        if (out_valid) begin
            n_out++;
            got = longint'($signed(out_data));
        end
    end

    typedef struct packed {
        logic [4:0]  ch;
        logic [11:0] raw;
        logic signed [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    // slot0: ch3 -100; slot1: ch3 +50 (shadowed); slot2: ch5 -300 unsigned clamp; slot3: ch9 zero
    localparam vec_t VECS [6] = '{
        '{5'd3,  12'd1000, 32'sd900,  8'd2},  // R2 lowest slot subtracts
        '{5'd3,  12'd40,   -32'sd60,  8'd2},  // R2 negative, no clamp
        '{5'd5,  12'd1000, 32'sd700,  8'd5},  // R5 positive kept
        '{5'd5,  12'd100,  32'sd0,    8'd5},  // R5 negative to zero
        '{5'd9,  12'd77,   32'sd77,   8'd3},  // R3 zero offset
        '{5'd12, 12'd4095, 32'sd4095, 8'd3}   // R3 no match
    };

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(input logic [4:0] ch, input logic [11:0] d);
        @(negedge clk);
        in_valid = 1'b1; in_chan = ch; in_data = d;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // back-to-back samples, one per cycle
    task automatic burst(input logic [4:0] ch, input int n, input logic [11:0] d0, input int step);
        @(negedge clk);
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b1; in_chan = ch; in_data = 12'(int'(d0) + i*step);
            @(negedge clk);
        end
        in_valid = 1'b0;
    endtask

    task automatic one(input logic [4:0] ch, input logic [11:0] d, input longint exp, input string req);
        n_out = 0;
        send(ch, d);
        repeat (5) @(negedge clk);
        chk(n_out == 1, {req, " pulse"}, n_out, 1);
        chk(got == exp, req, got, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1", out_valid, 0);
        rst = 1'b0;

        slot_chan[0] = 5'd3; slot_ofs[0] = 12'd100;
        slot_chan[1] = 5'd3; slot_ofs[1] = 12'd50; slot_add[1] = 1'b1;
        slot_chan[2] = 5'd5; slot_ofs[2] = 12'd300; slot_usat[2] = 1'b1;
        slot_chan[3] = 5'd9; slot_ofs[3] = 12'd0; slot_ssat[3] = 1'b1;

        foreach (VECS[k]) begin
            one(VECS[k].ch, VECS[k].raw, longint'(VECS[k].exp), $sformatf("R%0d", VECS[k].req));
        end

        // R4 add, with R6 signed clamp at both limits (signed wins over unsigned)
        slot_add[0] = 1'b1; slot_ssat[0] = 1'b1; slot_usat[0] = 1'b1; slot_ofs[0] = 12'd4000;
        one(5'd3, 12'd1000, 2047, "R6 high clamp");
        slot_ssat[0] = 1'b0; slot_usat[0] = 1'b0;
        one(5'd3, 12'd1000, 5000, "R4 add");
        slot_add[0] = 1'b0; slot_ssat[0] = 1'b1;
        one(5'd3, 12'd0, -2048, "R6 low clamp");
        slot_ssat[0] = 1'b0; slot_ofs[0] = 12'd100;

        // R7 gain: 1.5 on positive and negative, max coefficient
        gain_en = 1'b1; gain_coef = 14'd6144;
        one(5'd12, 12'd1001, 1502, "R7 positive");
        one(5'd3, 12'd41, -88, "R7 negative rounding");
        gain_coef = 14'd16383;
        one(5'd12, 12'd4095, (longint'(4095) * 16383 + 2048) >>> 12, "R7 max coef");
        gain_en = 1'b0;

        // R9 right shift ignored without oversampling, left shift applied
        ovs_rshift = 4'd3; res_lshift = 4'd3;
        one(5'd12, 12'd5, 40, "R9 no ovs");

        // R8 four samples 10,20,30,40 -> 100 >> 2 = 25, then R9 << 1 -> 50
        ovs_en = 1'b1; ovs_ratio = 10'd3; ovs_rshift = 4'd2; res_lshift = 4'd1;
        n_out = 0;
        burst(5'd12, 3, 12'd10, 10);
        repeat (5) @(negedge clk);
        chk(n_out == 0, "R8 partial no pulse", n_out, 0);
        burst(5'd12, 1, 12'd40, 0);
        repeat (5) @(negedge clk);
        chk(n_out == 1, "R8 one pulse", n_out, 1);
        chk(got == 50, "R8 R9 ovs value", got, 50);

        // R8 boundary: 1024 samples of full scale, shifted right by 10
        ovs_ratio = 10'd1023; ovs_rshift = 4'd10; res_lshift = 4'd0;
        n_out = 0;
        burst(5'd12, 1024, 12'd4095, 0);
        repeat (5) @(negedge clk);
        chk(n_out == 1, "R8 ratio 1023 pulse", n_out, 1);
        chk(got == 4095, "R8 ratio 1023 value", got, 4095);

        // R10 latency: strobe three edges after the accepting edge
        ovs_en = 1'b0; ovs_rshift = 4'd0;
        n_out = 0;
        @(negedge clk); in_valid = 1'b1; in_chan = 5'd12; in_data = 12'd9;
        @(negedge clk); in_valid = 1'b0;
        @(negedge clk); chk(out_valid == 1'b0, "R10 early", out_valid, 0);
        @(negedge clk); chk(out_valid == 1'b1, "R10 on time", out_valid, 1);

        // R1 reset mid-stream clears the strobe
        @(negedge clk); in_valid = 1'b1;
        @(negedge clk); in_valid = 1'b0; rst = 1'b1;
        @(negedge clk); chk(out_valid == 1'b0, "R1 mid reset", out_valid, 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        chk(out_valid == 1'b0, "R1 flushed", out_valid, 0);

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule